// File: doc/BRIEF.md
# Byte-Serialized Address/Data Link

This block is a matched sender and receiver that carry one 16-bit address and one 16-bit data word over a single shared 8-bit lane. A single request line frames each transfer. The sending side takes a parallel address and data word when a start pulse arrives. It then drives four bytes onto the lane, one per clock, while request is held high. The receiving side watches the request line and the lane, and rebuilds the two words. It raises a one-cycle completion flag once the fourth byte has been taken.

The sending side's lane outputs and the receiving side's lane inputs are separate ports. Chip-level wiring joins them, so either side can be driven or observed alone. Both sides run on one clock and share one synchronous, active-high reset. The receiving side never drives request. It only samples what the sending side presents.

Top module: `bytelink_top`

## Requirements
- R1: While reset is high and in the cycle after it is released, `link_req_o`, `busy_o` and `done_o` are 0, and `link_bus_o`, `rx_addr_o` and `rx_data_o` are all zero.
- R2: A start that is sampled while `busy_o` is low raises `link_req_o` from the next cycle. It then stays high for exactly four consecutive cycles.
- R3: The four request-high cycles carry, in this order, address bits 15:8, address bits 7:0, data bits 15:8 and data bits 7:0. These are the values on `addr_i`/`data_i` when the start was accepted. Changes to those inputs later in the transfer have no effect.
- R4: `link_bus_o` is all zero in every cycle where `link_req_o` is low.
- R5: `busy_o` is high from the cycle after an accepted start until one cycle after `link_req_o` falls. A start seen while `busy_o` is high is ignored.
- R6: After `link_req_o` falls it stays low for at least one cycle. With start held high continuously, the next request rises two cycles after the fall.
- R7: On each cycle with `link_req_i` high, the receiver takes one byte from `link_bus_i`. In the cycle after the fourth byte, `done_o` is 1 and `rx_addr_o`/`rx_data_o` show the rebuilt words, first byte most significant. They hold these values until the next completion.
- R8: If `link_req_i` falls after one, two or three bytes, the partial transfer is dropped. `done_o` stays 0 and `rx_addr_o`/`rx_data_o` keep their previous values. A full frame after it is decoded correctly.
- R9: `done_o` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request for a new transfer |
| addr_i | input | 16 | Address to send |
| data_i | input | 16 | Data word to send |
| busy_o | output | 1 | Sender is transferring or in its gap cycle |
| link_req_o | output | 1 | Request line driven by the sender |
| link_bus_o | output | 8 | Shared lane driven by the sender |
| link_req_i | input | 1 | Request line seen by the receiver |
| link_bus_i | input | 8 | Shared lane seen by the receiver |
| done_o | output | 1 | One-cycle pulse after a complete frame |
| rx_addr_o | output | 16 | Rebuilt address |
| rx_data_o | output | 16 | Rebuilt data word |

## Verification
A sender beat counter that is off by one shows up within one transfer. The request run comes out three or five cycles long, and each byte lands in the wrong half of the rebuilt word. A lost or stuck sender state shows as `busy_o` or `link_req_o` disagreeing with the start history on the very next cycle. A receiver count that is not cleared when request drops appears at the next full frame. In that case `done_o` fires early and `rx_addr_o`/`rx_data_o` carry stale bytes. A rebuilt word with its bytes in the wrong order appears in the cycle after the fourth byte.

// File: rtl/bytelink_pkg.sv
package bytelink_pkg;

  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_SEND = 2'd1,
    TX_GAP  = 2'd2
  } tx_state_e;

endpackage

// File: rtl/bl_serializer.sv
module bl_serializer
  import bytelink_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              busy_o,
  output logic              req_o,
  output logic [LANE_W-1:0] bus_o,
  output logic              accept_o,
  output logic              last_beat_o
);

  localparam int WORD_W = ADDR_W + DATA_W;
  localparam int BEATS  = WORD_W / LANE_W;
  localparam int CNT_W  = (BEATS > 1) ? $clog2(BEATS) : 1;

  // Most significant lane of the packed word goes out first.
  function automatic logic [LANE_W-1:0] top_lane(input logic [WORD_W-1:0] w);
    return w[WORD_W-1 -: LANE_W];
  endfunction

  tx_state_e         state_q;
  logic [WORD_W-1:0] shift_q;
  logic [CNT_W-1:0]  beat_q;

  assign accept_o    = start_i && (state_q == TX_IDLE);
  assign last_beat_o = (state_q == TX_SEND) && (beat_q == CNT_W'(BEATS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= TX_IDLE;
      shift_q <= '0;
      beat_q  <= '0;
    end else begin
      unique case (state_q)
        TX_IDLE: begin
          if (accept_o) begin
            shift_q <= {addr_i, data_i};
            beat_q  <= '0;
            state_q <= TX_SEND;
          end
        end
        TX_SEND: begin
          shift_q <= shift_q << LANE_W;
          if (last_beat_o) begin
            beat_q  <= '0;
            state_q <= TX_GAP;
          end else begin
            beat_q <= beat_q + CNT_W'(1);
          end
        end
        TX_GAP:  state_q <= TX_IDLE;
        default: state_q <= TX_IDLE;
      endcase
    end
  end

  assign req_o  = (state_q == TX_SEND);
  assign busy_o = (state_q != TX_IDLE);
  assign bus_o  = req_o ? top_lane(shift_q) : '0;

endmodule

// File: rtl/bl_deserializer.sv
module bl_deserializer #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_i,
  input  logic [LANE_W-1:0] bus_i,
  output logic              done_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              last_o
);

  localparam int WORD_W = ADDR_W + DATA_W;
  localparam int BEATS  = WORD_W / LANE_W;
  localparam int SH_W   = WORD_W - LANE_W;
  localparam int CNT_W  = (BEATS > 1) ? $clog2(BEATS) : 1;

  function automatic logic [ADDR_W-1:0] addr_part(input logic [WORD_W-1:0] w);
    return w[WORD_W-1 -: ADDR_W];
  endfunction

  function automatic logic [DATA_W-1:0] data_part(input logic [WORD_W-1:0] w);
    return w[DATA_W-1:0];
  endfunction

  logic [SH_W-1:0]   hist_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] full_w;

  assign full_w = {hist_q, bus_i};
  assign last_o = req_i && (cnt_q == CNT_W'(BEATS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= '0;
      cnt_q  <= '0;
      done_o <= 1'b0;
      addr_o <= '0;
      data_o <= '0;
    end else begin
      done_o <= last_o;
      if (!req_i) begin
        cnt_q <= '0;
      end else begin
        hist_q <= full_w[SH_W-1:0];
        if (last_o) begin
          cnt_q  <= '0;
          addr_o <= addr_part(full_w);
          data_o <= data_part(full_w);
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/bytelink_top.sv
module bytelink_top #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              busy_o,
  output logic              link_req_o,
  output logic [LANE_W-1:0] link_bus_o,
  input  logic              link_req_i,
  input  logic [LANE_W-1:0] link_bus_i,
  output logic              done_o,
  output logic [ADDR_W-1:0] rx_addr_o,
  output logic [DATA_W-1:0] rx_data_o
);

  localparam int BEATS = (ADDR_W + DATA_W) / LANE_W;

  // Internal events, named for the checker.
  logic tx_accept;
  logic tx_last;
  logic rx_last;

  bl_serializer #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANE_W(LANE_W)
  ) u_tx (
    .clk(clk), .rst(rst), .start_i(start_i), .addr_i(addr_i), .data_i(data_i),
    .busy_o(busy_o), .req_o(link_req_o), .bus_o(link_bus_o),
    .accept_o(tx_accept), .last_beat_o(tx_last)
  );

  bl_deserializer #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANE_W(LANE_W)
  ) u_rx (
    .clk(clk), .rst(rst), .req_i(link_req_i), .bus_i(link_bus_i),
    .done_o(done_o), .addr_o(rx_addr_o), .data_o(rx_data_o), .last_o(rx_last)
  );

endmodule

// File: rtl/bl_checker.sv
module bl_checker #(
  parameter int BEATS  = 4,
  parameter int LANE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic              busy_o,
  input logic              link_req_o,
  input logic [LANE_W-1:0] link_bus_o,
  input logic              link_req_i,
  input logic              done_o,
  input logic              tx_accept,
  input logic              tx_last,
  input logic              rx_last
);

  localparam int RUN_W = $clog2(BEATS + 2) + 1;

  // Length of the current request-high run, saturating.
  logic [RUN_W-1:0] run_q;
  always_ff @(posedge clk) begin
    if (rst) run_q <= '0;
    else if (!link_req_o) run_q <= '0;
    else if (run_q != '1) run_q <= run_q + RUN_W'(1);
  end

  p_req_after_accept_r2: assert property (@(posedge clk) disable iff (rst)
    tx_accept |=> link_req_o);

  p_req_run_short_r2: assert property (@(posedge clk) disable iff (rst)
    link_req_o |-> (run_q < RUN_W'(BEATS)));

  p_req_run_exact_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(link_req_o) |-> (run_q == RUN_W'(BEATS)));

  p_last_beat_drop_r2: assert property (@(posedge clk) disable iff (rst)
    tx_last |=> !link_req_o);

  p_bus_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    !link_req_o |-> (link_bus_o == '0));

  p_busy_cover_r5: assert property (@(posedge clk) disable iff (rst)
    link_req_o |-> busy_o);

  p_start_when_free_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(link_req_o) |-> ($past(start_i) && !$past(busy_o)));

  p_gap_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(link_req_o) |=> !link_req_o);

  p_done_follows_r7: assert property (@(posedge clk) disable iff (rst)
    rx_last |=> done_o);

  p_done_cause_r8: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(link_req_i));

  p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

endmodule

bind bytelink_top bl_checker #(
  .BEATS(BEATS), .LANE_W(LANE_W)
) u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .busy_o(busy_o),
  .link_req_o(link_req_o), .link_bus_o(link_bus_o), .link_req_i(link_req_i),
  .done_o(done_o), .tx_accept(tx_accept), .tx_last(tx_last), .rx_last(rx_last)
);

// File: tb/tb_bytelink_top.sv
`timescale 1ns/1ps
module tb_bytelink_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [15:0] addr_i = '0;
  logic [15:0] data_i = '0;
  logic        busy_o, link_req_o, done_o;
  logic [7:0]  link_bus_o;
  logic [15:0] rx_addr_o, rx_data_o;
  logic        inject = 1'b0;
  logic        inj_req = 1'b0;
  logic [7:0]  inj_bus = '0;
  logic        link_req_i;
  logic [7:0]  link_bus_i;

  int checks = 0;
  int errors = 0;
  logic [15:0] last_a = '0;
  logic [15:0] last_d = '0;

  always #4 clk = ~clk;

  assign link_req_i = inject ? inj_req : link_req_o;
  assign link_bus_i = inject ? inj_bus : link_bus_o;

  bytelink_top dut (
    .clk(clk), .rst(rst), .start_i(start_i), .addr_i(addr_i), .data_i(data_i),
    .busy_o(busy_o), .link_req_o(link_req_o), .link_bus_o(link_bus_o),
    .link_req_i(link_req_i), .link_bus_i(link_bus_i), .done_o(done_o),
    .rx_addr_o(rx_addr_o), .rx_data_o(rx_data_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] beat(input logic [15:0] a, input logic [15:0] d, input int k);
    logic [31:0] w;
    w = {a, d};
    return 8'((w >> (24 - 8 * k)) & 32'hFF);
  endfunction

  // Full transfer through the sender, looped back to the receiver.
  task automatic xfer(input logic [15:0] a, input logic [15:0] d, input bit hold);
    @(negedge clk);
    start_i = 1'b1; addr_i = a; data_i = d;
    @(negedge clk);
    check("R2 req beat0", 32'(link_req_o), 32'd1);
    check("R5 busy", 32'(busy_o), 32'd1);
    check("R3 beat0", 32'(link_bus_o), 32'(beat(a, d, 0)));
    if (hold) begin addr_i = ~a; data_i = ~d; end
    else start_i = 1'b0;
    for (int k = 1; k < 4; k++) begin
      @(negedge clk);
      check("R2 req held", 32'(link_req_o), 32'd1);
      check("R3 beat", 32'(link_bus_o), 32'(beat(a, d, k)));
    end
    @(negedge clk);
    check("R2 req drop", 32'(link_req_o), 32'd0);
    check("R4 bus quiet", 32'(link_bus_o), 32'd0);
    check("R5 busy in gap", 32'(busy_o), 32'd1);
    check("R7 done", 32'(done_o), 32'd1);
    check("R7 rx addr", 32'(rx_addr_o), 32'(a));
    check("R7 rx data", 32'(rx_data_o), 32'(d));
    last_a = a; last_d = d;
    @(negedge clk);
    check("R6 gap req", 32'(link_req_o), 32'd0);
    check("R9 done single", 32'(done_o), 32'd0);
    check("R5 busy clear", 32'(busy_o), 32'd0);
    start_i = 1'b0;
    @(negedge clk);
    check("R7 rx hold", 32'(rx_addr_o), 32'(a));
    check("R4 idle bus", 32'(link_bus_o), 32'd0);
  endtask

  // Frame injected straight into the receiver, n bytes long.
  task automatic inj_frame(input int n, input logic [15:0] a, input logic [15:0] d);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (k > 0) check("R8 no early done", 32'(done_o), 32'd0);
      inj_req = 1'b1; inj_bus = beat(a, d, k);
    end
    @(negedge clk);
    inj_req = 1'b0; inj_bus = '0;
    if (n == 4) begin
      check("R7 inj done", 32'(done_o), 32'd1);
      check("R7 inj addr", 32'(rx_addr_o), 32'(a));
      check("R7 inj data", 32'(rx_data_o), 32'(d));
      last_a = a; last_d = d;
    end else begin
      check("R8 partial no done", 32'(done_o), 32'd0);
      check("R8 addr kept", 32'(rx_addr_o), 32'(last_a));
      check("R8 data kept", 32'(rx_data_o), 32'(last_d));
    end
    @(negedge clk);
    check("R9 done low", 32'(done_o), 32'd0);
    check("R8 addr stable", 32'(rx_addr_o), 32'(last_a));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 req in reset", 32'(link_req_o), 32'd0);
    check("R1 busy in reset", 32'(busy_o), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 req", 32'(link_req_o), 32'd0);
    check("R1 bus", 32'(link_bus_o), 32'd0);
    check("R1 busy", 32'(busy_o), 32'd0);
    check("R1 done", 32'(done_o), 32'd0);
    check("R1 rx addr", 32'(rx_addr_o), 32'd0);
    check("R1 rx data", 32'(rx_data_o), 32'd0);

    xfer(16'h0000, 16'hFFFF, 1'b0);
    xfer(16'hFFFF, 16'h0000, 1'b0);
    for (int i = 0; i < 40; i++) begin
      logic [15:0] a, d;
      a = 16'(1 << (i % 16)) ^ 16'(i * 4099);
      d = ~a ^ 16'(i * 257);
      xfer(a, d, (i % 3) == 0);
    end

    // Start held through a whole transfer: restarts two cycles after the drop.
    @(negedge clk);
    start_i = 1'b1; addr_i = 16'h1234; data_i = 16'h5678;
    repeat (5) @(negedge clk);
    check("R6 req low after drop", 32'(link_req_o), 32'd0);
    @(negedge clk);
    check("R6 req low second gap", 32'(link_req_o), 32'd0);
    @(negedge clk);
    check("R6 restart", 32'(link_req_o), 32'd1);
    start_i = 1'b0;
    repeat (6) @(negedge clk);
    last_a = 16'h1234; last_d = 16'h5678;
    check("R7 second frame addr", 32'(rx_addr_o), 32'h1234);

    inject = 1'b1;
    for (int n = 1; n <= 3; n++) begin
      inj_frame(n, 16'hDEAD ^ 16'(n), 16'hBEEF);
      inj_frame(4, 16'h0F0F + 16'(n), 16'hA050 ^ 16'(n * 17));
    end
    inject = 1'b0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule